// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses the direction of conditional branches. A global history register records the outcomes of the most recent branches. The history is XORed with word-aligned address bits of the branch to pick one entry in a table of two-bit saturating counters. The upper bit of the picked counter is the guess.

Fetch logic presents a branch address on the lookup port and gets the guess back in the same cycle. The lookup port also returns the history used to form the index. When the branch resolves, that history snapshot is returned on the update port together with the address and the outcome. The entry that supplied the guess is then trained, even if other updates have moved the global history in the meantime. Only conditional branches train the table.

The block also keeps two running counts for accuracy measurement: accepted updates, and updates whose counter already pointed the right way.

Top module: `gshare_predictor`

## Requirements
- R1: Each accepted update shifts the global history one place toward the MSB. The resolved outcome (1 = taken, 0 = not taken) enters at bit 0. The lookup port shows the history on `pred_hist`.
- R2: The table index is address bits [HIST_W+1:2] XORed bit for bit with the history. Address bits 1:0 and bits above HIST_W+1 have no effect on the lookup or on the update.
- R3: `pred_taken` is bit 1 of the indexed counter, where 1 means taken. It is combinational from `pred_addr` and the present state.
- R4: An accepted taken update raises the indexed counter by one and holds it at 2'b11. An accepted not-taken update lowers it by one and holds it at 2'b00.
- R5: From 2'b11, one not-taken update leaves the entry predicting taken (2'b10). Three not-taken updates bring it to 2'b00, so one further taken update still predicts not taken.
- R6: Lookups alone never change the history, the counters or the counts.
- R7: An update is accepted only when `upd_valid` and `upd_cond` are both 1. Any other combination leaves history, counters and counts unchanged.
- R8: An update trains the entry indexed by `upd_hist` XOR `upd_addr` bits, not by the present history.
- R9: After reset every counter holds 2'b01, which predicts not taken. The history and both counts are zero.
- R10: When a lookup and an update address the same entry in one cycle, the lookup returns the value held before that update. The trained value is visible from the next cycle.
- R11: `upd_total` counts accepted updates. `upd_correct` counts accepted updates whose counter bit 1, before training, equalled the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_addr | input | ADDR_W | Branch address for lookup |
| pred_taken | output | 1 | Guessed direction, 1 = taken |
| pred_hist | output | HIST_W | History used by the present lookup |
| upd_valid | input | 1 | Update strobe |
| upd_cond | input | 1 | 1 for a conditional branch; jumps are ignored |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History snapshot taken at lookup time |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_total | output | CNT_W | Accepted update count |
| upd_correct | output | CNT_W | Count of updates the counter already agreed with |

## Verification
The embedded properties check these rules on every cycle:
- the history shift, and that the history holds when no update is accepted;
- the one-hot entry select;
- the counter step and saturation rules;
- that a lookup with no accepted update leaves the guess stable;
- the count increments.

Only the bench scenarios can show the other behaviours:
- the XOR hashing, and that low and high address bits are ignored;
- the multi-step walk from strongly taken down to 2'b00;
- the old-value read when a lookup and an update hit one entry in the same cycle;
- the use of the history snapshot rather than the present history;
- the accuracy counts against a reference model over a mixed trace.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_SNT = 2'b00;
    localparam ctr_t CTR_WNT = 2'b01;
    localparam ctr_t CTR_STK = 2'b11;

    // Saturating step of a two-bit direction counter.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken)
            nxt = (cur == CTR_STK) ? cur : cur + 2'd1;
        else
            nxt = (cur == CTR_SNT) ? cur : cur - 2'd1;
        return nxt;
    endfunction
endpackage

// File: rtl/gshare_hash.sv
module gshare_hash #(
    parameter int HIST_W = 10
) (
    input  logic [HIST_W-1:0] addr_bits,
    input  logic [HIST_W-1:0] hist,
    output logic [HIST_W-1:0] idx
);
    always_comb idx = addr_bits ^ hist;
endmodule

// File: rtl/gshare_hist.sv
module gshare_hist #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              taken_in,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) hist_d = {hist_q[HIST_W-2:0], taken_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign hist = hist_q;

    p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[0] == $past(taken_in)) &&
                     (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
    import gshare_pkg::*;
#(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_idx,
    output ctr_t              rd_ctr,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_taken,
    output ctr_t              wr_old
);
    localparam int DEPTH = 1 << HIST_W;

    ctr_t             tbl_q [DEPTH];
    ctr_t             tbl_d [DEPTH];
    logic [DEPTH-1:0] sel;

    // One-hot select of the entry being trained.
    for (genvar i = 0; i < DEPTH; i++) begin : g_sel
        assign sel[i] = (wr_idx == HIST_W'(i));
    end

    assign rd_ctr = tbl_q[rd_idx];
    assign wr_old = tbl_q[wr_idx];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            tbl_d[i] = (wr_en && sel[i]) ? ctr_step(tbl_q[i], wr_taken) : tbl_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= CTR_WNT;
        end else begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sel));

    p_sat_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_old == CTR_STK) |=> tbl_q[$past(wr_idx)] == CTR_STK);

    p_sat_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_old == CTR_SNT) |=> tbl_q[$past(wr_idx)] == CTR_SNT);

    p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_old != CTR_STK) |=>
            tbl_q[$past(wr_idx)] == $past(wr_old) + 2'd1);

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_old != CTR_SNT) |=>
            tbl_q[$past(wr_idx)] == $past(wr_old) - 2'd1);
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int HIST_W = 10,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic              upd_cond,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_taken,
    output logic [CNT_W-1:0]  upd_total,
    output logic [CNT_W-1:0]  upd_correct
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = HIST_W + IDX_LO - 1;

    typedef struct packed {
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] correct;
    } cnt_state_t;

    cnt_state_t        st_d, st_q;
    logic [HIST_W-1:0] hist;
    logic [HIST_W-1:0] rd_idx, wr_idx;
    ctr_t              rd_ctr, wr_old;
    logic              upd_fire;
    logic              unused_addr_bits;

    assign upd_fire = upd_valid && upd_cond;
    assign unused_addr_bits = ^{pred_addr[ADDR_W-1:IDX_HI+1], pred_addr[IDX_LO-1:0],
                                upd_addr[ADDR_W-1:IDX_HI+1], upd_addr[IDX_LO-1:0]};

    gshare_hist #(.HIST_W(HIST_W)) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_fire),
        .taken_in (upd_taken),
        .hist     (hist)
    );

    gshare_hash #(.HIST_W(HIST_W)) rd_hash_i (
        .addr_bits (pred_addr[IDX_HI:IDX_LO]),
        .hist      (hist),
        .idx       (rd_idx)
    );

    gshare_hash #(.HIST_W(HIST_W)) wr_hash_i (
        .addr_bits (upd_addr[IDX_HI:IDX_LO]),
        .hist      (upd_hist),
        .idx       (wr_idx)
    );

    gshare_pht #(.HIST_W(HIST_W)) pht_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (upd_fire),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken),
        .wr_old   (wr_old)
    );

    always_comb begin
        st_d = st_q;
        if (upd_fire) begin
            st_d.total = st_q.total + CNT_W'(1);
            if (wr_old[1] == upd_taken) st_d.correct = st_q.correct + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pred_taken  = rd_ctr[1];
    assign pred_hist   = hist;
    assign upd_total   = st_q.total;
    assign upd_correct = st_q.correct;

    p_read_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fire |=> ($stable(pred_addr) -> $stable(pred_taken)));

    p_total_r11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |=> upd_total == $past(upd_total) + CNT_W'(1));

    p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fire |=> $stable(upd_total) && $stable(upd_correct));

    p_correct_le_r11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_correct <= upd_total);
endmodule

// File: tb/gshare_predictor_tb.sv
module gshare_predictor_tb_top;
    localparam int HW = 4;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] pred_addr;
    logic          pred_taken;
    logic [HW-1:0] pred_hist;
    logic          upd_valid, upd_cond, upd_taken;
    logic [AW-1:0] upd_addr;
    logic [HW-1:0] upd_hist;
    logic [CW-1:0] upd_total, upd_correct;

    gshare_predictor #(.HIST_W(HW), .ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_taken(pred_taken),
        .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_cond(upd_cond),
        .upd_addr(upd_addr), .upd_hist(upd_hist), .upd_taken(upd_taken),
        .upd_total(upd_total), .upd_correct(upd_correct)
    );

    always #5 clk = ~clk;

    // Trace: {address[15:0], outcome}
    localparam logic [16:0] VEC [24] = '{
        {16'h0040, 1'b1}, {16'h0040, 1'b1}, {16'h0044, 1'b0}, {16'h0040, 1'b1},
        {16'h1230, 1'b1}, {16'h0040, 1'b0}, {16'h0044, 1'b0}, {16'h0048, 1'b1},
        {16'h0040, 1'b1}, {16'h0040, 1'b1}, {16'h0040, 1'b1}, {16'h004C, 1'b0},
        {16'h0050, 1'b1}, {16'h0054, 1'b1}, {16'h0040, 1'b0}, {16'h0044, 1'b1},
        {16'h8000, 1'b0}, {16'h0040, 1'b1}, {16'h0040, 1'b1}, {16'h0048, 1'b0},
        {16'h003C, 1'b1}, {16'h0040, 1'b1}, {16'h0044, 1'b0}, {16'h0040, 1'b1}
    };

    logic [1:0]    ref_tbl [1 << HW];
    logic [HW-1:0] ref_hist;
    int            ref_tot, ref_cor;
    int            n_chk = 0, n_bad = 0;
    bit            done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    function automatic logic [AW-1:0] addr_for(input int idx);
        return AW'(((idx ^ int'(ref_hist)) & ((1 << HW) - 1)) << 2);
    endfunction

    function automatic int ref_pred(input logic [AW-1:0] a);
        return int'(ref_tbl[ref_hist ^ a[HW+1:2]][1]);
    endfunction

    // Starts after a negedge, returns at the next negedge.
    task automatic apply_upd(input logic [AW-1:0] a, input logic [HW-1:0] h,
                             input logic t, input logic c);
        logic [HW-1:0] i;
        upd_valid = 1'b1; upd_cond = c; upd_addr = a; upd_hist = h; upd_taken = t;
        @(posedge clk);
        if (c) begin
            i = h ^ a[HW+1:2];
            ref_tot++;
            if (ref_tbl[i][1] == t) ref_cor++;
            if (t && ref_tbl[i] != 2'b11) ref_tbl[i] = ref_tbl[i] + 2'd1;
            if (!t && ref_tbl[i] != 2'b00) ref_tbl[i] = ref_tbl[i] - 2'd1;
            ref_hist = {ref_hist[HW-2:0], t};
        end
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] a);
        pred_addr = a;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pred_addr = '0; upd_valid = 1'b0; upd_cond = 1'b0;
        upd_addr = '0; upd_hist = '0; upd_taken = 1'b0;
        for (int i = 0; i < (1 << HW); i++) ref_tbl[i] = 2'b01;
        ref_hist = '0; ref_tot = 0; ref_cor = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R9: reset state
        chk_eq("R9 hist", int'(pred_hist), 0);
        chk_eq("R9 total", int'(upd_total), 0);
        chk_eq("R9 correct", int'(upd_correct), 0);
        for (int i = 0; i < (1 << HW); i++) begin
            look(AW'(i << 2));
            chk_eq("R9 counter predicts not taken", int'(pred_taken), 0);
        end

        // R2: low and high address bits ignored on update and lookup
        apply_upd(16'h000F, 4'h0, 1'b1, 1'b1);
        chk_eq("R1 history after taken", int'(pred_hist), 1);
        apply_upd(16'h400F, 4'h0, 1'b1, 1'b1);
        chk_eq("R1 history shift", int'(pred_hist), 3);
        look(addr_for(3) | 16'h0001);
        chk_eq("R2 low bits ignored", int'(pred_taken), 1);
        look(addr_for(3) | 16'h8002);
        chk_eq("R2 high bits ignored", int'(pred_taken), 1);
        look(addr_for(2));
        chk_eq("R3 neighbour untouched", int'(pred_taken), 0);

        // R4/R5: saturate up, then walk down to 00 at entry 7
        apply_upd(16'h001C, 4'h0, 1'b1, 1'b1);
        look(addr_for(7));
        chk_eq("R4 01 to 10 predicts taken", int'(pred_taken), 1);
        apply_upd(16'h001C, 4'h0, 1'b1, 1'b1);
        apply_upd(16'h001C, 4'h0, 1'b1, 1'b1);
        apply_upd(16'h001C, 4'h0, 1'b0, 1'b1);
        look(addr_for(7));
        chk_eq("R5 one not-taken from 11", int'(pred_taken), 1);
        apply_upd(16'h001C, 4'h0, 1'b0, 1'b1);
        look(addr_for(7));
        chk_eq("R5 two not-taken", int'(pred_taken), 0);
        apply_upd(16'h001C, 4'h0, 1'b0, 1'b1);
        apply_upd(16'h001C, 4'h0, 1'b0, 1'b1);
        apply_upd(16'h001C, 4'h0, 1'b1, 1'b1);
        look(addr_for(7));
        chk_eq("R4 saturated at 00 then taken", int'(pred_taken), 0);
        apply_upd(16'h001C, 4'h0, 1'b1, 1'b1);
        look(addr_for(7));
        chk_eq("R4 back to 10", int'(pred_taken), 1);

        // R10: same-entry lookup and update in one cycle
        look(addr_for(9));
        upd_valid = 1'b1; upd_cond = 1'b1; upd_addr = 16'h0024; upd_hist = 4'h0; upd_taken = 1'b1;
        #1;
        chk_eq("R10 old value during update", int'(pred_taken), 0);
        apply_upd(16'h0024, 4'h0, 1'b1, 1'b1);
        look(addr_for(9));
        chk_eq("R10 new value next cycle", int'(pred_taken), 1);

        // R8: training uses the supplied snapshot (idx = A ^ 5 = F)
        apply_upd(16'h0014, 4'hA, 1'b1, 1'b1);
        look(addr_for(15));
        chk_eq("R8 snapshot entry trained", int'(pred_taken), 1);
        look(addr_for(5 ^ int'(ref_hist)));
        chk_eq("R8 present-history entry", int'(pred_taken), ref_pred(addr_for(5 ^ int'(ref_hist))));

        // R7: jump and idle updates ignored
        begin
            int h0, t0, c0;
            h0 = int'(pred_hist); t0 = int'(upd_total); c0 = int'(upd_correct);
            apply_upd(addr_for(12), ref_hist, 1'b1, 1'b0);
            apply_upd(addr_for(12), ref_hist, 1'b1, 1'b0);
            look(addr_for(12));
            chk_eq("R7 counter unchanged", int'(pred_taken), 0);
            chk_eq("R7 history unchanged", int'(pred_hist), h0);
            chk_eq("R7 total unchanged", int'(upd_total), t0);
            chk_eq("R7 correct unchanged", int'(upd_correct), c0);
        end

        // R6: lookups only
        begin
            int h0, t0;
            h0 = int'(pred_hist); t0 = int'(upd_total);
            for (int i = 0; i < 8; i++) begin
                look(AW'(i * 12));
                @(negedge clk);
            end
            look(addr_for(7));
            chk_eq("R6 counter kept", int'(pred_taken), 1);
            chk_eq("R6 history kept", int'(pred_hist), h0);
            chk_eq("R6 total kept", int'(upd_total), t0);
        end

        // R3/R1/R11: trace against the reference model
        for (int v = 0; v < 24; v++) begin
            look(VEC[v][16:1]);
            chk_eq("R3 trace prediction", int'(pred_taken), ref_pred(VEC[v][16:1]));
            chk_eq("R1 trace history", int'(pred_hist), int'(ref_hist));
            apply_upd(VEC[v][16:1], pred_hist, VEC[v][0], 1'b1);
        end
        #1;
        chk_eq("R11 total", int'(upd_total), ref_tot);
        chk_eq("R11 correct", int'(upd_correct), ref_cor);

        finish_run();
    end
endmodule